// File: doc/BRIEF.md
# Scatter-Gather Segment Descriptor Queue

This block holds a short list of memory segment descriptors that software loads before a scatter-gather transfer starts. Every descriptor pairs an 8-byte aligned memory address with a command word giving the transfer direction, a per-entry flag that suppresses the completion interrupt, a byte-swap flag, and the segment length in 8-byte units minus one. Loading one descriptor takes two writes. The first write stages the address. The second write supplies the command word and moves both halves into the queue as one entry.

A downstream DMA engine sees the oldest entry together with a valid flag. It pulses a done strobe when that segment is finished, and the entry then leaves the queue. Software reads the pending count after a transfer to find descriptors that were never consumed. A control write can also empty and switch off the queue. Software normally enables the interrupt only on the final descriptor of a list, so one list completion raises the sticky done interrupt once. A push that cannot be accepted sets a sticky error flag.

Top module: `sgq_desc_queue`

## Requirements
- R1: After reset the queue is switched off (`q_off`=1), `pend_cnt` is 0, `head_vld` is 0, and both `push_err` and `done_irq` are 0.
- R2: `adr_wr` only stages `adr_wdata` and leaves the count unchanged. `cmd_wr` appends the previously staged address together with `cmd_wdata` as one entry, and `pend_cnt` rises by one after that edge. The command layout is bit 22 direction, bit 21 interrupt-suppress, bit 20 byte-swap, bits 19:0 length code. Entries leave the queue in the order they were pushed.
- R3: The queue holds at most DEPTH (16) entries. A push while `pend_cnt` equals DEPTH is dropped and sets `push_err`. Fullness is judged before any pop in the same cycle.
- R4: A push while the queue is switched off is dropped and sets `push_err`.
- R5: A push whose staged address has any of bits 2:0 set is rejected and sets `push_err`.
- R6: `cfg_wr` with `cfg_clr`=1 discards every entry and switches the queue off. `cfg_wr` with `cfg_clr`=0 switches it on and keeps any pending entries. A push in the same cycle as a `cfg_wr` is judged against the newly written state.
- R7: `head_vld` is 1 exactly when `pend_cnt` is nonzero. `eng_done` removes the head entry, and `pend_cnt` falls by one after that same edge. `eng_done` on an empty queue is ignored.
- R8: A push and a pop in the same cycle leave `pend_cnt` unchanged while the head advances.
- R9: `eng_done` on a head entry whose interrupt-suppress bit (bit 21) is 0 sets `done_irq`. A head entry with that bit set to 1 leaves `done_irq` unchanged.
- R10: `sts_wr` with `sts_wdata` bit 0 set clears `push_err`, and with bit 1 set clears `done_irq`. A new setting event in the same cycle as its clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adr_wr | input | 1 | Stage-address write strobe |
| adr_wdata | input | 64 | Segment address to stage |
| cmd_wr | input | 1 | Command write strobe, pushes one entry |
| cmd_wdata | input | 23 | Command word: direction, suppress, swap, length code |
| cfg_wr | input | 1 | Control write strobe |
| cfg_clr | input | 1 | Control value: 1 empties and switches off, 0 switches on |
| sts_wr | input | 1 | Flag clear strobe |
| sts_wdata | input | 2 | Write-one-to-clear mask: bit 0 error, bit 1 done interrupt |
| eng_done | input | 1 | Engine finished the head segment |
| q_off | output | 1 | Queue switched off |
| pend_cnt | output | 5 | Number of pending entries |
| head_vld | output | 1 | Head entry present |
| head_adr | output | 64 | Address of the head entry |
| head_cmd | output | 23 | Command word of the head entry |
| push_err | output | 1 | Sticky rejected-push flag |
| done_irq | output | 1 | Sticky segment-done interrupt |

## Verification
The assertions assume that every input is a known, single-cycle-qualified value from the first edge after reset. They make no assumption about ordering between strobes: pushes, pops, control writes and flag clears may coincide, and `eng_done` may arrive on an empty queue. The stimulus changes inputs only on the falling clock edge, so each rising edge samples stable, defined values. A randomized phase deliberately mixes colliding strobes and misaligned addresses so that the properties see those combinations.

// File: rtl/sgq_pkg.sv
package sgq_pkg;
   parameter int unsigned SGQ_SIZE_W = 20;

   typedef struct packed {
      logic                  dir;
      logic                  irq_off;
      logic                  swap;
      logic [SGQ_SIZE_W-1:0] size;
   } sgq_cmd_t;

   localparam int unsigned SGQ_CMD_W       = $bits(sgq_cmd_t);
   localparam int unsigned SGQ_IRQ_OFF_BIT = SGQ_SIZE_W + 1;
   localparam int unsigned SGQ_NFLAG       = 2;
   localparam int unsigned SGQ_STS_ERR     = 0;
   localparam int unsigned SGQ_STS_IRQ     = 1;
endpackage

// File: rtl/sgq_stage.sv
module sgq_stage #(
   parameter int unsigned ADDR_W  = 64,
   parameter int unsigned ALIGN_B = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      adr_wr,
   input  logic [ADDR_W-1:0]         adr_wdata,
   input  logic                      cmd_wr,
   input  logic                      q_en_nx,
   input  logic                      q_full,
   output logic [ADDR_W-ALIGN_B-1:0] push_adr,
   output logic                      push_ok,
   output logic                      push_bad
);
   logic [ADDR_W-1:0] stage_q;
   logic              misal;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stage_q <= '0;
      else if (adr_wr) stage_q <= adr_wdata;
   end

   assign misal    = |stage_q[ALIGN_B-1:0];
   assign push_ok  = cmd_wr & q_en_nx & ~q_full & ~misal;
   assign push_bad = cmd_wr & ~push_ok;
   assign push_adr = stage_q[ADDR_W-1:ALIGN_B];
endmodule

// File: rtl/sgq_store.sv
module sgq_store #(
   parameter int unsigned DEPTH   = 16,
   parameter int unsigned ENTRY_W = 84
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [ENTRY_W-1:0]         push_ent,
   input  logic                       pop,
   input  logic                       flush,
   output logic [ENTRY_W-1:0]         head_ent,
   output logic [$clog2(DEPTH+1)-1:0] cnt,
   output logic                       full
);
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CNT_W = $clog2(DEPTH+1);

   logic [ENTRY_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]   wr_q, rd_q, wr_inc, rd_inc;
   logic [CNT_W-1:0]   cnt_q;
   logic               pop_ok;

   assign pop_ok = pop && (cnt_q != '0);

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_free
         assign wr_inc = wr_q + 1'b1;
         assign rd_inc = rd_q + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_inc = (wr_q == PTR_W'(DEPTH-1)) ? '0 : wr_q + 1'b1;
         assign rd_inc = (rd_q == PTR_W'(DEPTH-1)) ? '0 : rd_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) mem[wr_q] <= push_ent;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else if (flush) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push)   wr_q <= wr_inc;
         if (pop_ok) rd_q <= rd_inc;
         cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop_ok);
      end
   end

   assign head_ent = mem[rd_q];
   assign cnt      = cnt_q;
   assign full     = (cnt_q == CNT_W'(DEPTH));
endmodule

// File: rtl/sgq_flags.sv
module sgq_flags #(
   parameter int unsigned NFLAG = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NFLAG-1:0] set_v,
   input  logic [NFLAG-1:0] clr_v,
   output logic [NFLAG-1:0] flag_q
);
   generate
      for (genvar i = 0; i < NFLAG; i++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        flag_q[i] <= 1'b0;
            else if (set_v[i]) flag_q[i] <= 1'b1;
            else if (clr_v[i]) flag_q[i] <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/sgq_desc_queue.sv
module sgq_desc_queue
   import sgq_pkg::*;
#(
   parameter int unsigned DEPTH   = 16,
   parameter int unsigned ADDR_W  = 64,
   parameter int unsigned ALIGN_B = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       adr_wr,
   input  logic [ADDR_W-1:0]          adr_wdata,
   input  logic                       cmd_wr,
   input  logic [SGQ_CMD_W-1:0]       cmd_wdata,
   input  logic                       cfg_wr,
   input  logic                       cfg_clr,
   input  logic                       sts_wr,
   input  logic [SGQ_NFLAG-1:0]       sts_wdata,
   input  logic                       eng_done,
   output logic                       q_off,
   output logic [$clog2(DEPTH+1)-1:0] pend_cnt,
   output logic                       head_vld,
   output logic [ADDR_W-1:0]          head_adr,
   output logic [SGQ_CMD_W-1:0]       head_cmd,
   output logic                       push_err,
   output logic                       done_irq
);
   localparam int unsigned CNT_W   = $clog2(DEPTH+1);
   localparam int unsigned HADR_W  = ADDR_W - ALIGN_B;
   localparam int unsigned ENTRY_W = HADR_W + SGQ_CMD_W;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("sgq_desc_queue: DEPTH must be at least 2");
      end
      if (ALIGN_B < 1 || ADDR_W <= ALIGN_B) begin : g_bad_align
         $error("sgq_desc_queue: ALIGN_B must be nonzero and below ADDR_W");
      end
   endgenerate

   logic                 off_q, en_nx, flush, full;
   logic                 push_ok, push_bad, irq_hit;
   logic [HADR_W-1:0]    push_adr;
   logic [ENTRY_W-1:0]   head_ent;
   logic [CNT_W-1:0]     cnt;
   logic [SGQ_NFLAG-1:0] set_v, clr_v, flag_q;
   sgq_cmd_t             head_c;

   assign en_nx = cfg_wr ? ~cfg_clr : ~off_q;
   assign flush = cfg_wr & cfg_clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      off_q <= 1'b1;
      else if (cfg_wr) off_q <= cfg_clr;
   end

   sgq_stage #(.ADDR_W(ADDR_W), .ALIGN_B(ALIGN_B)) u_stage (
      .clk(clk), .rst_n(rst_n),
      .adr_wr(adr_wr), .adr_wdata(adr_wdata),
      .cmd_wr(cmd_wr), .q_en_nx(en_nx), .q_full(full),
      .push_adr(push_adr), .push_ok(push_ok), .push_bad(push_bad)
   );

   sgq_store #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_store (
      .clk(clk), .rst_n(rst_n),
      .push(push_ok), .push_ent({push_adr, cmd_wdata}),
      .pop(eng_done), .flush(flush),
      .head_ent(head_ent), .cnt(cnt), .full(full)
   );

   assign head_c   = sgq_cmd_t'(head_ent[SGQ_CMD_W-1:0]);
   assign head_vld = (cnt != '0);
   assign irq_hit  = eng_done & head_vld & ~head_c.irq_off;

   always_comb begin
      set_v              = '0;
      set_v[SGQ_STS_ERR] = push_bad;
      set_v[SGQ_STS_IRQ] = irq_hit;
      clr_v              = {SGQ_NFLAG{sts_wr}} & sts_wdata;
   end

   sgq_flags #(.NFLAG(SGQ_NFLAG)) u_flags (
      .clk(clk), .rst_n(rst_n), .set_v(set_v), .clr_v(clr_v), .flag_q(flag_q)
   );

   assign q_off    = off_q;
   assign pend_cnt = cnt;
   assign head_adr = {head_ent[ENTRY_W-1:SGQ_CMD_W], {ALIGN_B{1'b0}}};
   assign head_cmd = head_c;
   assign push_err = flag_q[SGQ_STS_ERR];
   assign done_irq = flag_q[SGQ_STS_IRQ];
endmodule

// File: rtl/sgq_chk.sv
module sgq_chk #(
   parameter int unsigned DEPTH = 16
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       cmd_wr,
   input logic                       cfg_wr,
   input logic                       cfg_clr,
   input logic                       sts_wr,
   input logic                       sts_err_clr,
   input logic                       eng_done,
   input logic                       q_off,
   input logic [$clog2(DEPTH+1)-1:0] pend_cnt,
   input logic                       head_vld,
   input logic                       head_irq_off,
   input logic                       push_err,
   input logic                       done_irq
);
   localparam int unsigned CNT_W = $clog2(DEPTH+1);

   AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      pend_cnt <= CNT_W'(DEPTH));                                              // R3
   AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr && !cfg_wr && !eng_done && pend_cnt == CNT_W'(DEPTH)
      |=> pend_cnt == CNT_W'(DEPTH) && push_err);                              // R3
   AST_OFF_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr && q_off && !cfg_wr |=> push_err && pend_cnt == '0);              // R4
   AST_OFF_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      q_off |-> pend_cnt == '0);                                               // R6
   AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr && cfg_clr |=> q_off && pend_cnt == '0);                          // R6
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_wr && !eng_done && !cfg_wr |=> $stable(pend_cnt));                  // R2
   AST_VLD_CNT: assert property (@(posedge clk) disable iff (!rst_n)
      head_vld == (pend_cnt != '0));                                           // R7
   AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done && head_vld && !cmd_wr && !cfg_wr
      |=> pend_cnt == $past(pend_cnt) - CNT_W'(1));                            // R7
   AST_EMPTY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done && !head_vld && !cmd_wr |=> pend_cnt == '0);                    // R7
   AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done && head_vld && !head_irq_off |=> done_irq);                     // R9
   AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_irq) |-> $past(eng_done && head_vld && !head_irq_off));       // R9
   AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      push_err && !(sts_wr && sts_err_clr) |=> push_err);                      // R10
endmodule

bind sgq_desc_queue sgq_chk #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cfg_wr(cfg_wr), .cfg_clr(cfg_clr),
   .sts_wr(sts_wr), .sts_err_clr(sts_wdata[sgq_pkg::SGQ_STS_ERR]),
   .eng_done(eng_done), .q_off(q_off), .pend_cnt(pend_cnt), .head_vld(head_vld),
   .head_irq_off(head_cmd[sgq_pkg::SGQ_IRQ_OFF_BIT]),
   .push_err(push_err), .done_irq(done_irq)
);

// File: tb/sim_sgq_desc_queue.sv
`timescale 1ns/1ps
module sim_sgq_desc_queue;
   import sgq_pkg::*;
   localparam int DEPTH = 16;
   localparam int AW    = 64;
   localparam int CW    = SGQ_CMD_W;
   localparam int CNTW  = $clog2(DEPTH+1);

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          adr_wr = 0, cmd_wr = 0, cfg_wr = 0, cfg_clr = 0, sts_wr = 0, eng_done = 0;
   logic [AW-1:0] adr_wdata = '0;
   logic [CW-1:0] cmd_wdata = '0;
   logic [1:0]    sts_wdata = '0;
   logic          q_off, head_vld, push_err, done_irq;
   logic [CNTW-1:0] pend_cnt;
   logic [AW-1:0] head_adr;
   logic [CW-1:0] head_cmd;

   sgq_desc_queue u0 (
      .clk(clk), .rst_n(rst_n), .adr_wr(adr_wr), .adr_wdata(adr_wdata),
      .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .cfg_wr(cfg_wr), .cfg_clr(cfg_clr),
      .sts_wr(sts_wr), .sts_wdata(sts_wdata), .eng_done(eng_done),
      .q_off(q_off), .pend_cnt(pend_cnt), .head_vld(head_vld), .head_adr(head_adr),
      .head_cmd(head_cmd), .push_err(push_err), .done_irq(done_irq)
   );

   always #2.5 clk = ~clk;

   int checks = 0, errors = 0;
   bit finished = 0;

   // behavioural reference
   typedef logic [AW+CW-1:0] ent_t;
   ent_t          mq[$];
   logic [AW-1:0] m_stage;
   bit            m_off, m_err, m_irq, m_en, m_pop, m_ok, m_bad, m_iset;

   always @(posedge clk) begin
      if (!rst_n) begin
         mq.delete(); m_stage = '0; m_off = 1; m_err = 0; m_irq = 0;
      end else begin
         m_en   = cfg_wr ? !cfg_clr : !m_off;
         m_pop  = eng_done && (mq.size() > 0);
         m_iset = m_pop && !mq[0][SGQ_IRQ_OFF_BIT];
         m_ok   = cmd_wr && m_en && (mq.size() < DEPTH) && (m_stage[2:0] == 3'b000);
         m_bad  = cmd_wr && !m_ok;
         if (m_pop) void'(mq.pop_front());
         if (cfg_wr && cfg_clr) mq.delete();
         if (m_ok) mq.push_back({m_stage, cmd_wdata});
         if (adr_wr) m_stage = adr_wdata;
         if (sts_wr && sts_wdata[0]) m_err = 0;
         if (m_bad) m_err = 1;
         if (sts_wr && sts_wdata[1]) m_irq = 0;
         if (m_iset) m_irq = 1;
         if (cfg_wr) m_off = cfg_clr;
      end
   end

   task automatic chk(input string tag, input string what, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic cmp_model();
      chk("R7", "model count", 128'(pend_cnt), 128'(mq.size()));
      chk("R7", "model head_vld", 128'(head_vld), 128'(mq.size() > 0));
      if (mq.size() > 0) begin
         chk("R2", "model head_adr", 128'(head_adr), 128'(mq[0][AW+CW-1:CW]));
         chk("R2", "model head_cmd", 128'(head_cmd), 128'(mq[0][CW-1:0]));
      end
      chk("R6", "model q_off", 128'(q_off), 128'(m_off));
      chk("R3", "model push_err", 128'(push_err), 128'(m_err));
      chk("R9", "model done_irq", 128'(done_irq), 128'(m_irq));
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      cmp_model();
   endtask

   function automatic logic [CW-1:0] mk(input bit d, input bit ioff, input bit sw, input int unsigned sz);
      return {d, ioff, sw, 20'(sz)};
   endfunction

   task automatic stage(input logic [AW-1:0] a);
      adr_wr = 1; adr_wdata = a; tick(); adr_wr = 0;
   endtask

   task automatic push(input logic [AW-1:0] a, input logic [CW-1:0] c);
      stage(a);
      cmd_wr = 1; cmd_wdata = c; tick(); cmd_wr = 0;
   endtask

   task automatic pop1();
      eng_done = 1; tick(); eng_done = 0;
   endtask

   task automatic clr(input logic [1:0] m);
      sts_wr = 1; sts_wdata = m; tick(); sts_wr = 0; sts_wdata = '0;
   endtask

   task automatic cfg(input bit c);
      cfg_wr = 1; cfg_clr = c; tick(); cfg_wr = 0; cfg_clr = 0;
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog (all requirements): actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "reset count", 128'(pend_cnt), 0);
      chk("R1", "reset q_off", 128'(q_off), 1);
      chk("R1", "reset head_vld", 128'(head_vld), 0);
      chk("R1", "reset push_err", 128'(push_err), 0);
      chk("R1", "reset done_irq", 128'(done_irq), 0);

      // R4 push while switched off
      push(64'h1000, mk(0, 0, 0, 7));
      chk("R4", "off push err", 128'(push_err), 1);
      chk("R4", "off push count", 128'(pend_cnt), 0);
      clr(2'b01);
      chk("R10", "err cleared", 128'(push_err), 0);

      cfg(0);
      chk("R6", "enabled", 128'(q_off), 0);

      // R2 staging alone does nothing
      stage(64'h2008);
      chk("R2", "stage only count", 128'(pend_cnt), 0);
      push(64'h2000, mk(1, 1, 0, 63));
      push(64'h3000, mk(0, 1, 1, 1));
      push(64'h4000, mk(1, 0, 1, 20'hFFFFF));
      chk("R2", "three pushed", 128'(pend_cnt), 3);
      chk("R2", "head addr", 128'(head_adr), 128'(64'h2000));
      chk("R2", "head cmd", 128'(head_cmd), 128'(mk(1, 1, 0, 63)));

      // R5 misaligned
      push(64'h5004, mk(0, 0, 0, 3));
      chk("R5", "misaligned err", 128'(push_err), 1);
      chk("R5", "misaligned count", 128'(pend_cnt), 3);
      clr(2'b01);

      // R7 / R9 pop of suppressed entry
      pop1();
      chk("R7", "pop count", 128'(pend_cnt), 2);
      chk("R7", "pop head", 128'(head_adr), 128'(64'h3000));
      chk("R9", "suppressed no irq", 128'(done_irq), 0);

      // R8 push and pop together
      stage(64'h6000);
      cmd_wr = 1; cmd_wdata = mk(0, 0, 0, 5); eng_done = 1; tick();
      cmd_wr = 0; eng_done = 0;
      chk("R8", "push+pop count", 128'(pend_cnt), 2);
      chk("R8", "push+pop head", 128'(head_adr), 128'(64'h4000));

      pop1();
      chk("R9", "irq set", 128'(done_irq), 1);
      chk("R7", "count after irq pop", 128'(pend_cnt), 1);
      clr(2'b10);
      // R10 set wins over clear
      eng_done = 1; sts_wr = 1; sts_wdata = 2'b10; tick();
      eng_done = 0; sts_wr = 0; sts_wdata = '0;
      chk("R10", "set beats clear", 128'(done_irq), 1);
      chk("R7", "emptied", 128'(pend_cnt), 0);
      clr(2'b10);
      pop1();
      chk("R7", "done on empty count", 128'(pend_cnt), 0);
      chk("R7", "done on empty irq", 128'(done_irq), 0);

      // R3 fill to capacity
      for (int i = 0; i < DEPTH; i++) push(64'(i) << 4, mk(i[0], 1, 0, i));
      chk("R3", "full count", 128'(pend_cnt), DEPTH);
      push(64'hF000, mk(0, 1, 0, 1));
      chk("R3", "overflow err", 128'(push_err), 1);
      chk("R3", "overflow count", 128'(pend_cnt), DEPTH);
      clr(2'b01);
      stage(64'hE000);
      cmd_wr = 1; eng_done = 1; tick(); cmd_wr = 0; eng_done = 0;
      chk("R3", "full push with pop err", 128'(push_err), 1);
      chk("R3", "full push with pop count", 128'(pend_cnt), DEPTH - 1);
      clr(2'b01);

      // R6 flush and same-cycle pushes
      cfg(1);
      chk("R6", "flush count", 128'(pend_cnt), 0);
      chk("R6", "flush off", 128'(q_off), 1);
      stage(64'h7000);
      cfg_wr = 1; cfg_clr = 0; cmd_wr = 1; cmd_wdata = mk(0, 0, 0, 9); tick();
      cfg_wr = 0; cmd_wr = 0;
      chk("R6", "enable+push count", 128'(pend_cnt), 1);
      push(64'h7100, mk(0, 0, 0, 2));
      cfg(0);
      chk("R6", "re-enable keeps", 128'(pend_cnt), 2);
      cfg_wr = 1; cfg_clr = 1; cmd_wr = 1; tick(); cfg_wr = 0; cfg_clr = 0; cmd_wr = 0;
      chk("R6", "clear+push count", 128'(pend_cnt), 0);
      chk("R6", "clear+push err", 128'(push_err), 1);
      clr(2'b11);
      cfg(0);

      // randomized mix, reference compared every clock
      for (int n = 0; n < 3000; n++) begin
         int unsigned r = $urandom;
         adr_wr    = r[0];
         adr_wdata = {48'($urandom), 13'($urandom), (r[20:18] == 3'd0) ? 3'($urandom) : 3'd0};
         cmd_wr    = r[1] | r[2];
         cmd_wdata = CW'($urandom);
         eng_done  = r[3] & r[4];
         cfg_wr    = (r[9:5] == 5'd0);
         cfg_clr   = r[10] & r[11];
         sts_wr    = (r[14:12] == 3'd0);
         sts_wdata = r[16:15];
         tick();
      end
      adr_wr = 0; cmd_wr = 0; eng_done = 0; cfg_wr = 0; sts_wr = 0;
      tick();

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule